// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a read-only store that presents its contents one bit per clock on a single data line. It is meant to feed a configuration bitstream to a device that supplies the clock. An internal bit address starts at zero and advances on every clock edge at which the device is both selected and not held in reset. Within each stored byte the most significant bit is read first. The data line is modelled as a value plus an output enable, so that several devices can share one line.

Several devices can be daisy-chained on a common clock. Each device's chain-enable output drives the active-low select input of the next device. Once a device has delivered its last bit, it releases the data line and pulls its chain-enable output low, and the next device takes over. A parameter sets the polarity of the combined reset/output-enable pin. A small byte write port lets a test fill the store. A computed initial pattern is present at power-up.

Top module: `serial_cfg_rom`

## Requirements
- R1: At a clock edge where reset is active, the counter returns to zero and the past-end flag clears. After that edge `data_oe` is 0 and `ceo_n` is 1. The first enabled edge after reset delivers bit 0 again.
- R2: With `RST_ACTIVE_HIGH`=1, reset is active when `rst_oe`=1. With `RST_ACTIVE_HIGH`=0, reset is active when `rst_oe`=0. The opposite level enables output and counting.
- R3: Bit address a maps to bit 7-(a mod 8) of byte a/8 (MSB first). The k-th enabled edge after reset (k from 1) drives `data_o` with bit k-1 and sets `data_oe`=1 after that edge.
- R4: At an edge with `ce_n`=1 (and reset inactive), the counter is frozen and `data_oe` goes to 0. After a later enabled edge, reading resumes at the next unread address.
- R5: The edge that reads address 2^ADDR_W-1 delivers the last bit. At the next enabled edge `data_oe` goes to 0 and `ceo_n` goes to 0. Later edges neither wrap the address nor drive data again until a reset.
- R6: After the last bit has been read and while reset stays inactive, `ceo_n` takes the value `ce_n` had at each clock edge.
- R7: `data_oe`=1 and `ceo_n`=0 never occur together.
- R8: A clock edge with `wr_en`=1 stores `wr_byte` at byte `wr_byte_addr`, independent of reset and select. Later reads return the new value.
- R9: In a chain of two devices, the second device's stream starts two edges after the first device's last bit, with a single undriven cycle between them. The two devices never drive the line together.
- R10: `standby` is 1 after an edge with `ce_n`=1 and 0 after an edge with `ce_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Active-low select, also the chain input |
| wr_en | input | 1 | Test write strobe |
| wr_byte_addr | input | ADDR_W-3 | Test write byte address |
| wr_byte | input | 8 | Test write data |
| data_o | output | 1 | Serial data value |
| data_oe | output | 1 | Data line enable; 0 means high impedance |
| ceo_n | output | 1 | Active-low chain-enable output to the next device |
| standby | output | 1 | Low-power standby indication |

## Verification
Every output is a register, so the effect of any input is due after the first clock edge that samples it. Inputs change one nanosecond after a rising edge, and outputs are read at the same point after the following edge. The chain handoff is checked across its full span: the last bit of the first device, one undriven cycle, and the second device's first bit on the next edge. After a readout, changes on the select input reach `ceo_n` one edge later.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  typedef enum logic [1:0] {
    MODE_RESET   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_READ    = 2'd2,
    MODE_SPENT   = 2'd3
  } rom_mode_e;

endpackage

// File: rtl/cfgrom_ctrl.sv
module cfgrom_ctrl
  import cfgrom_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic      rst_oe,
  input  logic      ce_n,
  input  logic      past_tc,
  output logic      ce_active,
  output rom_mode_e mode
);

  logic rst_active;

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_high
      assign rst_active = rst_oe;
    end else begin : g_pol_low
      assign rst_active = ~rst_oe;
    end
  endgenerate

  assign ce_active = ~ce_n;

  always_comb begin
    if (rst_active)      mode = MODE_RESET;
    else if (!ce_active) mode = MODE_STANDBY;
    else if (past_tc)    mode = MODE_SPENT;
    else                 mode = MODE_READ;
  end

endmodule

// File: rtl/cfgrom_addr.sv
module cfgrom_addr
  import cfgrom_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  rom_mode_e         mode,
  output logic [ADDR_W-1:0] bit_addr,
  output logic              past_tc
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    case (mode)
      MODE_RESET: begin
        bit_addr <= '0;
        past_tc  <= 1'b0;
      end
      MODE_READ: begin
        if (bit_addr == LAST_ADDR) past_tc  <= 1'b1;
        else                       bit_addr <= bit_addr + 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/cfgrom_store.sv
module cfgrom_store #(
  parameter int         ADDR_W    = 12,
  parameter logic [7:0] INIT_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-4:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_bit_addr,
  output logic              rd_bit
);

  localparam int BYTE_AW = ADDR_W - 3;
  localparam int DEPTH   = 1 << BYTE_AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = INIT_SEED ^ 8'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_byte = mem[rd_bit_addr[ADDR_W-1:3]];
  assign rd_bit  = rd_byte[3'd7 - rd_bit_addr[2:0]];

endmodule

// File: rtl/cfgrom_drive.sv
module cfgrom_drive
  import cfgrom_pkg::*;
(
  input  logic      clk,
  input  rom_mode_e mode,
  input  logic      ce_active,
  input  logic      bit_in,
  output logic      data_o,
  output logic      data_oe,
  output logic      ceo_n,
  output logic      standby
);

  always_ff @(posedge clk) begin
    data_oe <= (mode == MODE_READ);
    data_o  <= (mode == MODE_READ) ? bit_in : 1'b0;
    ceo_n   <= (mode != MODE_SPENT);
    standby <= ~ce_active;
  end

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
  import cfgrom_pkg::*;
#(
  parameter int         ADDR_W          = 12,
  parameter bit         RST_ACTIVE_HIGH = 1'b1,
  parameter logic [7:0] INIT_SEED       = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_oe,
  input  logic              ce_n,
  input  logic              wr_en,
  input  logic [ADDR_W-4:0] wr_byte_addr,
  input  logic [7:0]        wr_byte,
  output logic              data_o,
  output logic              data_oe,
  output logic              ceo_n,
  output logic              standby
);

  rom_mode_e         mode;
  logic              ce_active;
  logic              past_tc;
  logic [ADDR_W-1:0] bit_addr;
  logic              cur_bit;

  cfgrom_ctrl #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_ctrl (
    .rst_oe    (rst_oe),
    .ce_n      (ce_n),
    .past_tc   (past_tc),
    .ce_active (ce_active),
    .mode      (mode)
  );

  cfgrom_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .mode     (mode),
    .bit_addr (bit_addr),
    .past_tc  (past_tc)
  );

  cfgrom_store #(.ADDR_W(ADDR_W), .INIT_SEED(INIT_SEED)) u_store (
    .clk         (clk),
    .wr_en       (wr_en),
    .wr_addr     (wr_byte_addr),
    .wr_data     (wr_byte),
    .rd_bit_addr (bit_addr),
    .rd_bit      (cur_bit)
  );

  cfgrom_drive u_drive (
    .clk       (clk),
    .mode      (mode),
    .ce_active (ce_active),
    .bit_in    (cur_bit),
    .data_o    (data_o),
    .data_oe   (data_oe),
    .ceo_n     (ceo_n),
    .standby   (standby)
  );

endmodule

// File: rtl/cfgrom_checker.sv
module cfgrom_checker #(
  parameter int ADDR_W          = 12,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input logic              clk,
  input logic              rst_oe,
  input logic              ce_n,
  input logic              data_oe,
  input logic              ceo_n,
  input logic              standby,
  input logic [ADDR_W-1:0] bit_addr,
  input logic              past_tc
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic rst_act;
  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

  // R1: the cycle after a reset edge shows a cleared counter and released outputs
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst_act)
    $past(rst_act) |-> (bit_addr == '0 && !past_tc && !data_oe && ceo_n));

  // R3: an enabled read below the last address moves to the next address
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && !past_tc && bit_addr != LAST_ADDR)
      |=> (bit_addr == ADDR_W'($past(bit_addr) + 1'b1)));

  // R4 / R10: a deselected edge quiets the line and raises standby
  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |=> (!data_oe && standby));

  // R5: once past the end, the address never wraps
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst_act)
    past_tc |=> (past_tc && bit_addr == $past(bit_addr)));

  // R6: a low chain output needs a selected edge after the readout
  assert_ceo_cause_R6: assert property (@(posedge clk) disable iff (rst_act)
    !ceo_n |-> ($past(!ce_n) && $past(past_tc)));

  // R7: never drive data while handing off
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst_act)
    data_oe |-> ceo_n);

endmodule

bind serial_cfg_rom cfgrom_checker #(
  .ADDR_W          (ADDR_W),
  .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH)
) u_chk (
  .clk      (clk),
  .rst_oe   (rst_oe),
  .ce_n     (ce_n),
  .data_oe  (data_oe),
  .ceo_n    (ceo_n),
  .standby  (standby),
  .bit_addr (bit_addr),
  .past_tc  (past_tc)
);

// File: tb/serial_cfg_rom_test.sv
`timescale 1ns/1ps
module serial_cfg_rom_test;

  localparam int AW    = 8;
  localparam int NBITS = 1 << AW;
  localparam int NBYTE = NBITS / 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst0  = 1'b1;  // active-high device
  logic          rstn1 = 1'b0;  // active-low device
  logic          ce0_n = 1'b1;
  logic          wr_en0 = 1'b0, wr_en1 = 1'b0;
  logic [AW-4:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;

  logic d0, oe0, ceo0_n, sb0;
  logic d1, oe1, ceo1_n, sb1;

  int checks = 0;
  int failures = 0;

  serial_cfg_rom #(.ADDR_W(AW), .RST_ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rst_oe(rst0), .ce_n(ce0_n), .wr_en(wr_en0),
    .wr_byte_addr(wr_addr), .wr_byte(wr_data),
    .data_o(d0), .data_oe(oe0), .ceo_n(ceo0_n), .standby(sb0));

  serial_cfg_rom #(.ADDR_W(AW), .RST_ACTIVE_HIGH(1'b0)) uut_n (
    .clk(clk), .rst_oe(rstn1), .ce_n(ceo0_n), .wr_en(wr_en1),
    .wr_byte_addr(wr_addr), .wr_byte(wr_data),
    .data_o(d1), .data_oe(oe1), .ceo_n(ceo1_n), .standby(sb1));

  logic line_oe, line_d;
  assign line_oe = oe0 | oe1;
  assign line_d  = oe0 ? d0 : d1;

  function automatic logic [7:0] byte_of(int dev, int i);
    if (dev == 0) return 8'((i * 37 + 5) & 255);
    return 8'((i * 91 + 60) & 255) ^ 8'hA5;
  endfunction

  function automatic logic bit_of(int dev, int a);
    logic [7:0] b;
    b = byte_of(dev, a / 8);
    return b[7 - (a % 8)];
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_load();  // R8
    for (int i = 0; i < NBYTE; i++) begin
      wr_addr = (AW-3)'(i); wr_data = byte_of(0, i); wr_en0 = 1'b1; tick();
      wr_en0 = 1'b0;
      wr_data = byte_of(1, i); wr_en1 = 1'b1; tick();
      wr_en1 = 1'b0;
    end
  endtask

  task automatic t_reset();  // R1, R2
    rst0 = 1'b1; rstn1 = 1'b0; ce0_n = 1'b0;
    tick(); tick();
    check(oe0 == 1'b0,    "R1 oe0 in reset", oe0, 0);
    check(ceo0_n == 1'b1, "R1 ceo0 in reset", ceo0_n, 1);
    check(oe1 == 1'b0,    "R2 oe1 held by low pin", oe1, 0);
    check(ceo1_n == 1'b1, "R2 ceo1 held by low pin", ceo1_n, 1);
  endtask

  task automatic t_read();  // R3, R10
    rst0 = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick();
      check(oe0 == 1'b1,            "R3 oe0 during read", oe0, 1);
      check(d0 == bit_of(0, k),     "R3 serial bit", d0, bit_of(0, k));
    end
    check(sb0 == 1'b0, "R10 standby low when selected", sb0, 0);
  endtask

  task automatic t_standby();  // R4, R10
    ce0_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(oe0 == 1'b0, "R4 line released in standby", oe0, 0);
      check(sb0 == 1'b1, "R10 standby high", sb0, 1);
    end
    ce0_n = 1'b0;
    tick();
    check(oe0 == 1'b1 && d0 == bit_of(0, 20), "R4 resume at next address", d0, bit_of(0, 20));
    tick();
    check(d0 == bit_of(0, 21), "R4 continue after resume", d0, bit_of(0, 21));
  endtask

  task automatic t_restart();  // R1
    rst0 = 1'b1;
    tick();
    check(oe0 == 1'b0, "R1 mid-read reset releases line", oe0, 0);
    rst0 = 1'b0;
    tick();
    check(d0 == bit_of(0, 0), "R1 restart at bit 0", d0, bit_of(0, 0));
    tick();
    check(d0 == bit_of(0, 1), "R1 restart bit 1", d0, bit_of(0, 1));
  endtask

  task automatic t_write();  // R8
    rst0 = 1'b1; tick();
    wr_addr = '0; wr_data = 8'h80; wr_en0 = 1'b1; tick();
    wr_en0 = 1'b0; rst0 = 1'b0;
    tick();
    check(d0 == 1'b1, "R8 rewritten bit 0", d0, 1);
    tick();
    check(d0 == 1'b0, "R8 rewritten bit 1", d0, 0);
    rst0 = 1'b1;
    wr_addr = '0; wr_data = byte_of(0, 0); wr_en0 = 1'b1; tick();
    wr_en0 = 1'b0;
  endtask

  task automatic t_cascade();  // R5, R7, R9, R2
    rst0 = 1'b1; rstn1 = 1'b0; ce0_n = 1'b0; tick();
    rst0 = 1'b0; rstn1 = 1'b1;
    for (int k = 0; k < NBITS; k++) begin
      tick();
      check(oe0 && !oe1 && line_d == bit_of(0, k), "R9 first device stream", line_d, bit_of(0, k));
      check(!(oe0 && !ceo0_n), "R7 no drive during handoff", ceo0_n, 1);
    end
    tick();
    check(oe0 == 1'b0 && ceo0_n == 1'b0, "R5 handoff after last bit", ceo0_n, 0);
    check(line_oe == 1'b0, "R9 single idle cycle", line_oe, 0);
    for (int k = 0; k < NBITS; k++) begin
      tick();
      check(oe1 && !oe0 && line_d == bit_of(1, k), "R9 second device stream (R2 low pin inactive)", line_d, bit_of(1, k));
    end
    tick();
    check(oe1 == 1'b0 && ceo1_n == 1'b0, "R5 second device handoff", ceo1_n, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(line_oe == 1'b0, "R5 no wrap after end", line_oe, 0);
    end
  endtask

  task automatic t_follow();  // R6, R1
    ce0_n = 1'b1; tick();
    check(ceo0_n == 1'b1 && oe0 == 1'b0, "R6 ceo follows deselect", ceo0_n, 1);
    ce0_n = 1'b0; tick();
    check(ceo0_n == 1'b0 && oe0 == 1'b0, "R6 ceo follows reselect", ceo0_n, 0);
    rst0 = 1'b1; tick();
    check(ceo0_n == 1'b1, "R1 reset releases ceo", ceo0_n, 1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_load();
    t_reset();
    t_read();
    t_standby();
    t_restart();
    t_write();
    t_cascade();
    t_follow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule